// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Logic

This block is the issue stage of a two-wide in-order pipeline. Each cycle fetch presents a 64-bit packet that holds two instructions, already reduced to a kind code, two source register indices and a destination index. The block decides whether nothing, only the older instruction, or both instructions leave this cycle. The integer-side pipe takes integer ALU operations and all loads, including FP loads. The FP pipe takes FP arithmetic.

Both instructions issue together only when the older one is integer-side and the younger one is an FP operation, and neither depends on the other. If only the older one issues, the packet is held. In the next cycle the younger instruction is treated as the older slot of a one-instruction group. Sources are checked against a scoreboard busy vector. Sources are also checked against an internal one-cycle load shadow. As a result, a loaded value cannot be read by the younger instruction of its own packet, nor by either instruction of the following issue cycle.

Register index 0 means "no register". It never blocks and is never written.

Top module: `pair_issue_ctl`

## Requirements
- R1: A synchronous active-low reset clears the split state and the load shadow. After reset, a packet is always handled starting from its left half. While `pkt_valid` is low, all outputs are 0.
- R2: Kind codes are 0 = integer ALU, 1 = integer load, 2 = FP load, 3 = FP operation; kinds 0 to 2 are integer-side. Take a packet whose left instruction is integer-side and whose right instruction is an FP operation, with no blocked source and no dependence between the two. It issues both in the same cycle: `int_go=1, int_pick=0, fp_go=1, fp_pick=1, fetch_hold=0`.
- R3: In some packets the left instruction is an FP operation, or the right instruction is not one. Here the left instruction issues alone, on the pipe given by its kind, with pick 0, and `fetch_hold=1`. In the next issue cycle the right instruction issues alone, on its own pipe, with pick 1 and `fetch_hold=0`. A pick output is 0 whenever its go output is 0.
- R4: If the instruction in the older position cannot issue, nothing issues that cycle and `fetch_hold=1`.
- R5: A nonzero source whose bit in `sb_busy` is set blocks its instruction. For the right instruction, the packet is then split. Index 0 never blocks, whatever `sb_busy[0]` holds.
- R6: A right instruction that reads a nonzero left destination, or that writes the same nonzero destination, does not pair. The packet splits as in R3.
- R7: Suppose a load with a nonzero destination issues in cycle t. In cycle t+1, any instruction that reads that register does not issue. From cycle t+2 onward the shadow no longer blocks.
- R8: An FP load (kind 2) in the left slot pairs with an FP operation in the right slot under the conditions of R2.
- R9: `fetch_hold` is high exactly when `pkt_valid` is high and the packet has not been fully issued by the end of this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Fetch packet present |
| lft_kind | input | 2 | Kind code of left (older) instruction |
| lft_rs_a | input | REG_W | Left source A index |
| lft_rs_b | input | REG_W | Left source B index |
| lft_rd | input | REG_W | Left destination index |
| rgt_kind | input | 2 | Kind code of right (younger) instruction |
| rgt_rs_a | input | REG_W | Right source A index |
| rgt_rs_b | input | REG_W | Right source B index |
| rgt_rd | input | REG_W | Right destination index |
| sb_busy | input | 2**REG_W | Scoreboard pending-write bit per register |
| int_go | output | 1 | Issue to integer-side pipe |
| int_pick | output | 1 | Packet half sent to integer pipe (1 = right) |
| fp_go | output | 1 | Issue to FP pipe |
| fp_pick | output | 1 | Packet half sent to FP pipe (1 = right) |
| fetch_hold | output | 1 | Keep the current packet for another cycle |

## Verification
The checker assumes that fetch keeps `pkt_valid` high and the packet stable while `fetch_hold` is high. It also assumes that the scoreboard bit of register 0 carries no meaning. The bench only changes the packet after the hold drops, and it separates sweep packets with an idle cycle, so that a load shadow from one case cannot leak into the next. The sweep sets `sb_busy[0]` permanently high to exercise the index-0 rule. Busy bits are raised only for the first cycle of a case, so that every blocked instruction eventually issues within a bounded schedule.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Instruction kind as delivered by the pre-decoder.
    typedef enum logic [1:0] {
        K_ALU  = 2'd0,
        K_LDI  = 2'd1,
        K_LDF  = 2'd2,
        K_FPOP = 2'd3
    } kind_t;

    // True for kinds that travel down the integer-side pipe.
    function automatic logic is_int_side(input kind_t k);
        return k != K_FPOP;
    endfunction

    // True for kinds whose result arrives late (load delay).
    function automatic logic is_load(input kind_t k);
        return (k == K_LDI) || (k == K_LDF);
    endfunction

endpackage

// File: rtl/pic_slot_mux.sv
// Selects which packet half sits in the older issue position.
// Assumes: right_sel is high only while the left half has already issued.
module pic_slot_mux
    import pic_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic                  right_sel,
    input  kind_t                 lft_kind,
    input  logic [REG_W-1:0]      lft_rs_a,
    input  logic [REG_W-1:0]      lft_rs_b,
    input  logic [REG_W-1:0]      lft_rd,
    input  kind_t                 rgt_kind,
    input  logic [REG_W-1:0]      rgt_rs_a,
    input  logic [REG_W-1:0]      rgt_rs_b,
    input  logic [REG_W-1:0]      rgt_rd,
    output kind_t                 eff_kind,
    output logic [1:0][REG_W-1:0] eff_rs,
    output logic [REG_W-1:0]      eff_rd
);

    // Route the chosen half onto the older-position fields.
    always_comb begin
        if (right_sel) begin
            eff_kind  = rgt_kind;
            eff_rs[0] = rgt_rs_a;
            eff_rs[1] = rgt_rs_b;
            eff_rd    = rgt_rd;
        end else begin
            eff_kind  = lft_kind;
            eff_rs[0] = lft_rs_a;
            eff_rs[1] = lft_rs_b;
            eff_rd    = lft_rd;
        end
    end

endmodule

// File: rtl/pic_hazard.sv
// Hazard screen for one instruction: scoreboard busy, load shadow, and
// dependence on an older instruction of the same group.
// Assumes: index 0 is the null register; older_rd = 0 means no older slot.
module pic_hazard #(
    parameter int REG_W = 6,
    parameter int NSRC  = 2,
    localparam int NREG = 1 << REG_W
) (
    input  logic [NSRC-1:0][REG_W-1:0] rs,
    input  logic [REG_W-1:0]           own_rd,
    input  logic [NREG-1:0]            busy,
    input  logic                       shd_vld,
    input  logic [REG_W-1:0]           shd_rd,
    input  logic [REG_W-1:0]           older_rd,
    output logic                       blocked
);

    logic [NSRC-1:0] src_hit;
    logic            waw_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic nz;
        logic busy_hit;
        logic shd_hit;
        logic raw_hit;
        // Per-source comparisons; a null index matches nothing.
        always_comb begin
            nz       = rs[i] != '0;
            busy_hit = nz && busy[rs[i]];
            shd_hit  = nz && shd_vld && (rs[i] == shd_rd);
            raw_hit  = nz && (rs[i] == older_rd);
            src_hit[i] = busy_hit || shd_hit || raw_hit;
        end
    end

    // Same-destination conflict with the older slot, then combine.
    always_comb begin
        waw_hit = (own_rd != '0) && (own_rd == older_rd);
        blocked = (|src_hit) || waw_hit;
    end

endmodule

// File: rtl/pic_load_shadow.sv
// Remembers the destination of a load issued in the previous cycle.
// Assumes: at most one load issues per cycle (loads use the older position).
module pic_load_shadow
    import pic_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  kind_t            kind,
    input  logic [REG_W-1:0] rd,
    output logic             shd_vld,
    output logic [REG_W-1:0] shd_rd
);

    // Shadow lasts exactly one cycle after the load issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_vld <= 1'b0;
            shd_rd  <= '0;
        end else begin
            shd_vld <= issue && is_load(kind) && (rd != '0);
            shd_rd  <= rd;
        end
    end

endmodule

// File: rtl/pic_pair_ctl.sv
// Issue decision and split-packet state for the two-wide group.
// Assumes: the packet stays stable while fetch_hold is high.
module pic_pair_ctl
    import pic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pkt_valid,
    input  kind_t lft_kind,
    input  kind_t rgt_kind,
    input  kind_t eff_kind,
    input  logic  eff_blk,
    input  logic  rgt_blk,
    output logic  second_half,
    output logic  eff_go,
    output logic  int_go,
    output logic  int_pick,
    output logic  fp_go,
    output logic  fp_pick,
    output logic  fetch_hold
);

    logic pair_go;
    logic pkt_done;

    // Decide who issues and on which pipe.
    always_comb begin
        eff_go  = pkt_valid && !eff_blk;
        pair_go = !second_half && eff_go && is_int_side(lft_kind)
                  && (rgt_kind == K_FPOP) && !rgt_blk;
        int_go   = eff_go && is_int_side(eff_kind);
        int_pick = int_go && second_half;
        fp_go    = (eff_go && (eff_kind == K_FPOP)) || pair_go;
        fp_pick  = pair_go || (fp_go && second_half);
        pkt_done = second_half ? eff_go : pair_go;
        fetch_hold = pkt_valid && !pkt_done;
    end

    // Track whether the left half of the held packet has left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_half <= 1'b0;
        end else if (pkt_valid) begin
            if (second_half) second_half <= !eff_go;
            else             second_half <= eff_go && !pair_go;
        end
    end

endmodule

// File: rtl/pair_issue_ctl.sv
// Two-wide in-order issue: pairs an integer-side instruction with a
// following FP operation, splits otherwise, and enforces the load delay.
// Assumes: fetch holds the packet while fetch_hold is high; index 0 is null.
module pair_issue_ctl
    import pic_pkg::*;
#(
    parameter int REG_W = 6,
    localparam int NREG = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [1:0]       lft_kind,
    input  logic [REG_W-1:0] lft_rs_a,
    input  logic [REG_W-1:0] lft_rs_b,
    input  logic [REG_W-1:0] lft_rd,
    input  logic [1:0]       rgt_kind,
    input  logic [REG_W-1:0] rgt_rs_a,
    input  logic [REG_W-1:0] rgt_rs_b,
    input  logic [REG_W-1:0] rgt_rd,
    input  logic [NREG-1:0]  sb_busy,
    output logic             int_go,
    output logic             int_pick,
    output logic             fp_go,
    output logic             fp_pick,
    output logic             fetch_hold
);

    kind_t                 lk, rk, eff_kind;
    logic [1:0][REG_W-1:0] eff_rs;
    logic [1:0][REG_W-1:0] rgt_rs;
    logic [REG_W-1:0]      eff_rd, eff_rs_a, eff_rs_b, shd_rd;
    logic                  second_half, eff_go, eff_blk, rgt_blk, shd_vld;

    // Cast raw kind codes and pack the right sources.
    always_comb begin
        lk        = kind_t'(lft_kind);
        rk        = kind_t'(rgt_kind);
        rgt_rs[0] = rgt_rs_a;
        rgt_rs[1] = rgt_rs_b;
        eff_rs_a  = eff_rs[0];
        eff_rs_b  = eff_rs[1];
    end

    pic_slot_mux #(.REG_W(REG_W)) u_mux (
        .right_sel(second_half),
        .lft_kind(lk), .lft_rs_a(lft_rs_a), .lft_rs_b(lft_rs_b), .lft_rd(lft_rd),
        .rgt_kind(rk), .rgt_rs_a(rgt_rs_a), .rgt_rs_b(rgt_rs_b), .rgt_rd(rgt_rd),
        .eff_kind(eff_kind), .eff_rs(eff_rs), .eff_rd(eff_rd)
    );

    pic_hazard #(.REG_W(REG_W), .NSRC(2)) u_haz_old (
        .rs(eff_rs), .own_rd(eff_rd), .busy(sb_busy),
        .shd_vld(shd_vld), .shd_rd(shd_rd), .older_rd('0),
        .blocked(eff_blk)
    );

    pic_hazard #(.REG_W(REG_W), .NSRC(2)) u_haz_young (
        .rs(rgt_rs), .own_rd(rgt_rd), .busy(sb_busy),
        .shd_vld(shd_vld), .shd_rd(shd_rd), .older_rd(lft_rd),
        .blocked(rgt_blk)
    );

    pic_load_shadow #(.REG_W(REG_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .issue(eff_go), .kind(eff_kind), .rd(eff_rd),
        .shd_vld(shd_vld), .shd_rd(shd_rd)
    );

    pic_pair_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .lft_kind(lk), .rgt_kind(rk), .eff_kind(eff_kind),
        .eff_blk(eff_blk), .rgt_blk(rgt_blk),
        .second_half(second_half), .eff_go(eff_go),
        .int_go(int_go), .int_pick(int_pick), .fp_go(fp_go), .fp_pick(fp_pick),
        .fetch_hold(fetch_hold)
    );

endmodule

// File: rtl/pair_issue_ctl_chk.sv
// Property checker for pair_issue_ctl, attached by bind.
// Assumes: observes only; drives nothing.
module pair_issue_ctl_chk #(
    parameter int REG_W = 6,
    localparam int NREG = 1 << REG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [NREG-1:0]  sb_busy,
    input logic [REG_W-1:0] eff_rs_a,
    input logic [REG_W-1:0] eff_rs_b,
    input logic             shd_vld,
    input logic [REG_W-1:0] shd_rd,
    input logic             int_go,
    input logic             int_pick,
    input logic             fp_go,
    input logic             fp_pick,
    input logic             fetch_hold
);

    a_r2_pair_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (int_go && fp_go) |-> (!int_pick && fp_pick && !fetch_hold));

    a_r3_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && fetch_hold && ((int_go && !int_pick) || (fp_go && !fp_pick)))
        |=> !((int_go && !int_pick) || (fp_go && !fp_pick)));

    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !int_go && !fp_go) |-> fetch_hold);

    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (eff_rs_a != '0) && sb_busy[eff_rs_a]) |-> (!int_go && !fp_go));

    a_r7_shadow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && shd_vld && (shd_rd != '0)
         && ((eff_rs_a == shd_rd) || (eff_rs_b == shd_rd))) |-> (!int_go && !fp_go));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> (!int_go && !fp_go && !fetch_hold));

endmodule

bind pair_issue_ctl pair_issue_ctl_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .sb_busy(sb_busy),
    .eff_rs_a(eff_rs_a), .eff_rs_b(eff_rs_b), .shd_vld(shd_vld), .shd_rd(shd_rd),
    .int_go(int_go), .int_pick(int_pick), .fp_go(fp_go), .fp_pick(fp_pick),
    .fetch_hold(fetch_hold)
);

// File: tb/pair_issue_ctl_test.sv
module pair_issue_ctl_test;

    localparam int REG_W = 6;
    localparam int NREG  = 1 << REG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_valid = 1'b0;
    logic [1:0]       lft_kind = '0, rgt_kind = '0;
    logic [REG_W-1:0] lft_rs_a = '0, lft_rs_b = '0, lft_rd = '0;
    logic [REG_W-1:0] rgt_rs_a = '0, rgt_rs_b = '0, rgt_rd = '0;
    logic [NREG-1:0]  sb_busy = '0;
    logic             int_go, int_pick, fp_go, fp_pick, fetch_hold;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pair_issue_ctl #(.REG_W(REG_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .lft_kind(lft_kind), .lft_rs_a(lft_rs_a), .lft_rs_b(lft_rs_b), .lft_rd(lft_rd),
        .rgt_kind(rgt_kind), .rgt_rs_a(rgt_rs_a), .rgt_rs_b(rgt_rs_b), .rgt_rd(rgt_rd),
        .sb_busy(sb_busy),
        .int_go(int_go), .int_pick(int_pick), .fp_go(fp_go), .fp_pick(fp_pick),
        .fetch_hold(fetch_hold)
    );

    // Output vector order: {int_go, int_pick, fp_go, fp_pick, fetch_hold}
    task automatic chk(input logic [4:0] exp, input string tag);
        logic [4:0] got;
        got = {int_go, int_pick, fp_go, fp_pick, fetch_hold};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic pkt(input logic [1:0] lk, input int la, input int lb, input int ld,
                       input logic [1:0] rk, input int ra, input int rb, input int rd);
        pkt_valid = 1'b1;
        lft_kind = lk; lft_rs_a = REG_W'(la); lft_rs_b = REG_W'(lb); lft_rd = REG_W'(ld);
        rgt_kind = rk; rgt_rs_a = REG_W'(ra); rgt_rs_b = REG_W'(rb); rgt_rd = REG_W'(rd);
    endtask

    // Check in mid-cycle, then move to the next falling edge.
    task automatic step(input logic [4:0] exp, input string tag);
        #2;
        chk(exp, tag);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        pkt_valid = 1'b0;
        sb_busy = '0;
        step(5'b00000, tag);
    endtask

    initial begin
        #(100000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        step(5'b00000, "R1 in reset");
        rst_n = 1'b1;
        step(5'b00000, "R1 after reset idle");

        // R1: reset clears a split state mid-packet.
        pkt(2'd0, 1, 0, 2, 2'd0, 3, 0, 4);
        step(5'b10001, "R1 left alone");
        rst_n = 1'b0; pkt_valid = 1'b0;
        step(5'b00000, "R1 reset mid-split");
        rst_n = 1'b1;
        pkt(2'd0, 1, 0, 2, 2'd0, 3, 0, 4);
        step(5'b10001, "R1 restarts at left half");
        step(5'b11000, "R3 right half after reset");
        idle("R9 idle");

        // Sweep: left kind x right kind x dependence case.
        for (int lk = 0; lk < 4; lk++) begin
            for (int rk = 0; rk < 4; rk++) begin
                for (int dep = 0; dep < 5; dep++) begin
                    bit lint, lload, pairs;
                    int t0, d, last;
                    string tag;
                    lint  = (lk != 3);
                    lload = (lk == 1) || (lk == 2);
                    pairs = lint && (rk == 3) && (dep == 0 || dep == 4);
                    t0    = (dep == 4) ? 1 : 0;
                    d     = (dep == 1 && lload) ? 1 : 0;
                    last  = pairs ? t0 : t0 + 1 + d;
                    if (dep == 4)      tag = "R4";
                    else if (dep == 3) tag = "R5";
                    else if (dep != 0) tag = (d != 0) ? "R7" : "R6";
                    else if (pairs)    tag = (lk == 2) ? "R8" : "R2";
                    else               tag = "R3";
                    pkt(2'(lk), 1, 0, 2, 2'(rk),
                        (dep == 1) ? 2 : 33, 34, (dep == 2) ? 2 : 35);
                    for (int cyc = 0; cyc <= last; cyc++) begin
                        logic [4:0] e;
                        sb_busy = '0;
                        sb_busy[0] = 1'b1;
                        if (cyc == 0 && dep == 3) sb_busy[33] = 1'b1;
                        if (cyc == 0 && dep == 4) sb_busy[1]  = 1'b1;
                        if (cyc < t0)                  e = 5'b00001;
                        else if (pairs)                e = 5'b10110;
                        else if (cyc == t0)            e = (lk == 3) ? 5'b00101 : 5'b10001;
                        else if (cyc < last)           e = 5'b00001;
                        else                           e = (rk == 3) ? 5'b00110 : 5'b11000;
                        step(e, tag);
                    end
                    idle("R9 gap");
                end
            end
        end

        // R7: integer load shadow blocks the whole next packet for one cycle.
        pkt(2'd1, 1, 0, 5, 2'd3, 33, 34, 35);
        step(5'b10110, "R7 load pairs");
        pkt(2'd0, 5, 0, 6, 2'd3, 36, 0, 37);
        step(5'b00001, "R7 shadow stall");
        step(5'b10110, "R7 shadow over");
        idle("R9 gap");
        pkt(2'd0, 5, 0, 6, 2'd3, 36, 0, 37);
        step(5'b10110, "R7 expired after gap");
        idle("R9 gap");

        // R7: FP load shadow hits the right instruction of the next packet.
        pkt(2'd2, 1, 0, 40, 2'd3, 33, 34, 35);
        step(5'b10110, "R8 FP load pairs");
        pkt(2'd0, 1, 0, 2, 2'd3, 40, 0, 41);
        step(5'b10001, "R7 right blocked by shadow");
        step(5'b00110, "R7 right issues next cycle");
        idle("R9 gap");

        // R9: valid-low cycle with busy activity stays quiet.
        sb_busy = '1;
        step(5'b00000, "R9 valid low");
        sb_busy = '0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule